// File: doc/BRIEF.md
# Two-Wire Programming Port Sequencer

This block is the host side of a two-wire serial programming port: one clock line that it always drives, and one data line that it drives when writing and releases when the target answers. A local controller hands it one operation at a time over a valid/ready handshake. The operation is a bare 6-bit command, a command followed by a written word, a command followed by a read word, or a complete one-word program-and-verify cycle. The block shapes the serial waveform, holds every minimum delay between frames, and reports completion with a one-cycle done pulse. That pulse carries the word read back and a verify-failure flag.

All timing is counted in system clock cycles from parameters: the clock high and low half-periods, the data setup/hold figure, the general inter-frame gap, the programming wait and the discharge wait. Both half-periods are raised to at least the setup/hold figure. A word goes out bit 0 first. Write data changes only when the serial clock rises, so the target can latch it when the clock falls.

Top module: `prg_serial_host`

## Requirements
- R1: `req_ready` is high only when no frame is running and the last frame's trailing gap has elapsed. A request is accepted on a cycle where `req_valid` and `req_ready` are both high, and `req_ready` is low in the next cycle.
- R2: Frames go out bit 0 first. A command frame is 6 serial clocks carrying `req_cmd`. A data frame is 16 clocks: position 0 is 0, positions 1 to 12 carry the 12-bit word, and positions 13 to 15 are 0.
- R3: The serial clock is high for max(HALF_HI, SETUP_HOLD) cycles and low for at least max(HALF_LO, SETUP_HOLD) cycles. The data line and its enable change only when the clock rises or when a frame ends, so they are steady for at least SETUP_HOLD cycles on both sides of every falling edge.
- R4: During a read data frame, `pgm_dat_oe` is low for all 16 clocks. The input is sampled in the last system cycle of each high half. `rd_data` holds the word from positions 1 to 12; whatever the target returns in positions 13 and 14 is ignored.
- R5: Between the last falling edge of one frame and the first rising edge of the next, at least T_DLY cycles pass. This applies to command→data, data→command and command→command.
- R6: After a command frame with code 0x08 (begin programming), at least T_PROG cycles pass before the next rising edge. After code 0x0E (end programming), at least T_DIS cycles pass. This also holds when these codes are sent as bare commands.
- R7: `req_op` = 3 (program-verify) sends, in this order: command 0x02 with a data frame holding `req_wdata`, command 0x08, command 0x0E, then command 0x04 with a read data frame.
- R8: On a program-verify, `mismatch` is 1 exactly when the 12 bits read back differ from `req_wdata`. On every other operation `mismatch` is 0.
- R9: `done` is a single-cycle pulse at the end of every operation, with `rd_data` and `mismatch` valid in that cycle. Operation codes: 0 = bare command, 1 = command 0x02 plus write frame, 2 = command 0x04 plus read frame, 3 = program-verify. For codes 0 and 1, `rd_data` is 0.
- R10: In the cycle after reset is released, `pgm_clk` is 0, `pgm_dat_oe` is 1, `pgm_dat_o` is 0, `done` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Operation request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_op | input | 2 | Operation code (0 command, 1 write, 2 read, 3 program-verify) |
| req_cmd | input | 6 | Command code for a bare command operation |
| req_wdata | input | 12 | Word to write or to program and verify |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 12 | Word read back from the target |
| mismatch | output | 1 | Verify read-back differs from the written word |
| pgm_clk | output | 1 | Serial clock to the target |
| pgm_dat_o | output | 1 | Serial data driven to the target |
| pgm_dat_oe | output | 1 | Data line drive enable (0 = released) |
| pgm_dat_i | input | 1 | Serial data returned by the target |

## Verification
The bench attaches a target model that decodes the waveform on serial clock edges, keeps a small word memory, and returns reads with the two top positions set to 1. Program-verify is run four ways: with a clean target, with a target that corrupts bit 0 of the stored word, and with the all-ones and all-zeros words. Together these separate a working compare from one that is stuck, one that ignores the top returned bits, and one that sees the wrong bit order. Bare begin and end commands are also sent on their own, followed by a read; this shows whether the long waits are tied to the command code or only to the built-in cycle. The model times every edge and gap against the programmed minima, using a low half-period set below the setup/hold figure so that the clamp is tested.

// File: rtl/prg_pkg.sv
// Shared definitions for the two-wire programming sequencer.
// Assumes a single 12-bit word width and fixed 6/16-clock frame lengths.
package prg_pkg;

    localparam int WORD_W     = 12;
    localparam int CMD_BITS   = 6;
    localparam int FRAME_BITS = 16;

    // Operation codes on the request interface
    typedef enum logic [1:0] {
        OP_CMD    = 2'd0,
        OP_LOAD   = 2'd1,
        OP_READ   = 2'd2,
        OP_VERIFY = 2'd3
    } prg_op_e;

    // Command codes the sequencer issues by itself
    localparam logic [CMD_BITS-1:0] CODE_LOAD  = 6'h02;
    localparam logic [CMD_BITS-1:0] CODE_READ  = 6'h04;
    localparam logic [CMD_BITS-1:0] CODE_BEGIN = 6'h08;
    localparam logic [CMD_BITS-1:0] CODE_END   = 6'h0E;

    // Individual frames an operation is built from
    typedef enum logic [2:0] {
        STP_NONE,
        STP_RAW,
        STP_LOAD_CMD,
        STP_WR,
        STP_BEGIN,
        STP_END,
        STP_READ_CMD,
        STP_RD
    } prg_step_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/prg_gap_timer.sv
// Down-counter for the idle gap between frames.
// Assumes load is a one-cycle pulse; expired is high while the count is zero.
module prg_gap_timer #(
    parameter int GW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [GW-1:0] load_val,
    output logic          expired
);

    logic [GW-1:0] cnt;

    // Load a new gap length or count the current one down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/prg_frame_engine.sv
// Shifts one serial frame bit 0 first: clock rises with new data, then falls.
// Assumes go arrives only while idle and HI_CYC, LO_CYC are both at least 1.
// Read frames release the data line for the whole frame and capture positions 1..12
// in the last high cycle of each bit.
module prg_frame_engine import prg_pkg::*; #(
    parameter int HI_CYC = 2,
    parameter int LO_CYC = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  go,
    input  logic                  go_long,
    input  logic                  go_read,
    input  logic [FRAME_BITS-1:0] go_word,
    output logic                  fin,
    output logic [WORD_W-1:0]     rx_word,
    output logic                  ser_clk,
    output logic                  ser_dat,
    output logic                  ser_oe,
    input  logic                  ser_in
);

    localparam int TW = $clog2(imax(HI_CYC, LO_CYC) + 1);
    localparam int IW = $clog2(FRAME_BITS);
    localparam logic [TW-1:0] HI_LOAD = TW'(HI_CYC - 1);
    localparam logic [TW-1:0] LO_LOAD = TW'(LO_CYC - 1);
    localparam logic [IW-1:0] LAST_LONG  = IW'(FRAME_BITS - 1);
    localparam logic [IW-1:0] LAST_SHORT = IW'(CMD_BITS - 1);

    logic                  busy;
    logic                  ph_hi;
    logic                  rd_mode;
    logic [TW-1:0]         tmr;
    logic [IW-1:0]         bit_idx;
    logic [IW-1:0]         last_idx;
    logic [FRAME_BITS-1:0] tx;
    logic                  in_window;

    // Word positions 1..12 of a frame hold the data word
    assign in_window = (bit_idx >= IW'(1)) && (bit_idx <= IW'(WORD_W));

    // Walk bits and half-periods; drive clock/data and capture read bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            ph_hi    <= 1'b0;
            rd_mode  <= 1'b0;
            tmr      <= '0;
            bit_idx  <= '0;
            last_idx <= '0;
            tx       <= '0;
            rx_word  <= '0;
            fin      <= 1'b0;
            ser_clk  <= 1'b0;
            ser_dat  <= 1'b0;
            ser_oe   <= 1'b1;
        end else begin
            fin <= 1'b0;
            if (!busy) begin
                if (go) begin
                    busy     <= 1'b1;
                    ph_hi    <= 1'b1;
                    rd_mode  <= go_read;
                    tmr      <= HI_LOAD;
                    bit_idx  <= '0;
                    last_idx <= go_long ? LAST_LONG : LAST_SHORT;
                    tx       <= go_word;
                    ser_clk  <= 1'b1;
                    ser_dat  <= go_read ? 1'b0 : go_word[0];
                    ser_oe   <= !go_read;
                end
            end else if (tmr != '0) begin
                tmr <= tmr - 1'b1;
            end else if (ph_hi) begin
                ph_hi   <= 1'b0;
                ser_clk <= 1'b0;
                tmr     <= LO_LOAD;
                if (rd_mode && in_window) begin
                    rx_word <= {ser_in, rx_word[WORD_W-1:1]};
                end
            end else if (bit_idx == last_idx) begin
                busy    <= 1'b0;
                fin     <= 1'b1;
                ser_dat <= 1'b0;
                ser_oe  <= 1'b1;
            end else begin
                bit_idx <= bit_idx + 1'b1;
                ph_hi   <= 1'b1;
                ser_clk <= 1'b1;
                tmr     <= HI_LOAD;
                tx      <= {1'b0, tx[FRAME_BITS-1:1]};
                ser_dat <= rd_mode ? 1'b0 : tx[1];
            end
        end
    end

endmodule

// File: rtl/prg_ctrl.sv
// Turns one request into a chain of frames separated by minimum gaps.
// Assumes the frame engine is idle whenever a go pulse is issued and that the
// gap timer is loaded on the same edge the gap phase is entered.
module prg_ctrl import prg_pkg::*; #(
    parameter int T_DLY  = 250,
    parameter int T_PROG = 250000,
    parameter int T_DIS  = 25000,
    parameter int GW     = 18
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [1:0]            req_op,
    input  logic [CMD_BITS-1:0]   req_cmd,
    input  logic [WORD_W-1:0]     req_wdata,
    input  logic                  frame_fin,
    input  logic [WORD_W-1:0]     frame_rx,
    output logic                  frame_go,
    output logic                  frame_long,
    output logic                  frame_read,
    output logic [FRAME_BITS-1:0] frame_word,
    input  logic                  gap_expired,
    output logic                  gap_load,
    output logic [GW-1:0]         gap_val,
    output logic                  done,
    output logic [WORD_W-1:0]     rd_data,
    output logic                  mismatch
);

    typedef enum logic [1:0] {PH_IDLE, PH_FRAME, PH_GAP} phase_e;

    phase_e                phase;
    prg_step_e             cur;
    prg_step_e             after;
    prg_op_e               op_q;
    logic [CMD_BITS-1:0]   cmd_q;
    logic [WORD_W-1:0]     data_q;
    prg_step_e             nxt_step;
    logic [GW-1:0]         nxt_gap;
    logic                  fin_done;
    prg_step_e             first_step;

    // Trailing gap owed after a command frame, chosen by its code
    function automatic logic [GW-1:0] gap_for(input logic [CMD_BITS-1:0] c);
        if (c == CODE_BEGIN) return GW'(T_PROG);
        if (c == CODE_END)   return GW'(T_DIS);
        return GW'(T_DLY);
    endfunction

    assign req_ready = (phase == PH_IDLE);

    // First frame of each operation
    always_comb begin
        case (prg_op_e'(req_op))
            OP_CMD:  first_step = STP_RAW;
            OP_READ: first_step = STP_READ_CMD;
            default: first_step = STP_LOAD_CMD;
        endcase
    end

    // Frame contents for the current step
    always_comb begin
        frame_long = 1'b0;
        frame_read = 1'b0;
        frame_word = '0;
        case (cur)
            STP_RAW:      frame_word = FRAME_BITS'(cmd_q);
            STP_LOAD_CMD: frame_word = FRAME_BITS'(CODE_LOAD);
            STP_BEGIN:    frame_word = FRAME_BITS'(CODE_BEGIN);
            STP_END:      frame_word = FRAME_BITS'(CODE_END);
            STP_READ_CMD: frame_word = FRAME_BITS'(CODE_READ);
            STP_WR: begin
                frame_long = 1'b1;
                frame_word = {{(FRAME_BITS-WORD_W-1){1'b0}}, data_q, 1'b0};
            end
            STP_RD: begin
                frame_long = 1'b1;
                frame_read = 1'b1;
            end
            default: frame_word = '0;
        endcase
    end

    // Successor step, trailing gap and completion for the frame now running
    always_comb begin
        nxt_step = STP_NONE;
        nxt_gap  = GW'(T_DLY);
        fin_done = 1'b0;
        case (cur)
            STP_RAW: begin
                nxt_gap  = gap_for(cmd_q);
                fin_done = 1'b1;
            end
            STP_LOAD_CMD: nxt_step = STP_WR;
            STP_WR: begin
                if (op_q == OP_VERIFY) nxt_step = STP_BEGIN;
                else                   fin_done = 1'b1;
            end
            STP_BEGIN: begin
                nxt_step = STP_END;
                nxt_gap  = GW'(T_PROG);
            end
            STP_END: begin
                nxt_step = STP_READ_CMD;
                nxt_gap  = GW'(T_DIS);
            end
            STP_READ_CMD: nxt_step = STP_RD;
            STP_RD:       fin_done = 1'b1;
            default:      nxt_step = STP_NONE;
        endcase
    end

    assign gap_load = (phase == PH_FRAME) && frame_fin;
    assign gap_val  = nxt_gap;

    // Phase machine: accept, run frame, hold gap, then next frame or idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            cur      <= STP_NONE;
            after    <= STP_NONE;
            op_q     <= OP_CMD;
            cmd_q    <= '0;
            data_q   <= '0;
            frame_go <= 1'b0;
            done     <= 1'b0;
            rd_data  <= '0;
            mismatch <= 1'b0;
        end else begin
            frame_go <= 1'b0;
            done     <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        op_q     <= prg_op_e'(req_op);
                        cmd_q    <= req_cmd;
                        data_q   <= req_wdata;
                        cur      <= first_step;
                        frame_go <= 1'b1;
                        phase    <= PH_FRAME;
                    end
                end
                PH_FRAME: begin
                    if (frame_fin) begin
                        after <= nxt_step;
                        phase <= PH_GAP;
                        if (fin_done) begin
                            done     <= 1'b1;
                            rd_data  <= (cur == STP_RD) ? frame_rx : '0;
                            mismatch <= (cur == STP_RD) && (op_q == OP_VERIFY)
                                        && (frame_rx != data_q);
                        end
                    end
                end
                default: begin
                    if (gap_expired) begin
                        if (after == STP_NONE) begin
                            phase <= PH_IDLE;
                            cur   <= STP_NONE;
                        end else begin
                            cur      <= after;
                            frame_go <= 1'b1;
                            phase    <= PH_FRAME;
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/prg_serial_host.sv
// Top of the host-side two-wire programming sequencer.
// Assumes all timing parameters are given in system clock cycles and that the
// data line is turned around outside this block using pgm_dat_oe.
module prg_serial_host import prg_pkg::*; #(
    parameter int HALF_HI    = 25,
    parameter int HALF_LO    = 25,
    parameter int SETUP_HOLD = 25,
    parameter int T_DLY      = 250,
    parameter int T_PROG     = 250000,
    parameter int T_DIS      = 25000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [1:0]          req_op,
    input  logic [CMD_BITS-1:0] req_cmd,
    input  logic [WORD_W-1:0]   req_wdata,
    output logic                done,
    output logic [WORD_W-1:0]   rd_data,
    output logic                mismatch,
    output logic                pgm_clk,
    output logic                pgm_dat_o,
    output logic                pgm_dat_oe,
    input  logic                pgm_dat_i
);

    localparam int HI_EFF  = imax(HALF_HI, SETUP_HOLD);
    localparam int LO_EFF  = imax(HALF_LO, SETUP_HOLD);
    localparam int GAP_MAX = imax(T_DLY, imax(T_PROG, T_DIS));
    localparam int GW      = $clog2(GAP_MAX + 1);

    logic                  frame_go;
    logic                  frame_long;
    logic                  frame_read;
    logic [FRAME_BITS-1:0] frame_word;
    logic                  frame_fin;
    logic [WORD_W-1:0]     frame_rx;
    logic                  gap_load;
    logic [GW-1:0]         gap_val;
    logic                  gap_expired;

    prg_ctrl #(
        .T_DLY (T_DLY),
        .T_PROG(T_PROG),
        .T_DIS (T_DIS),
        .GW    (GW)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_op     (req_op),
        .req_cmd    (req_cmd),
        .req_wdata  (req_wdata),
        .frame_fin  (frame_fin),
        .frame_rx   (frame_rx),
        .frame_go   (frame_go),
        .frame_long (frame_long),
        .frame_read (frame_read),
        .frame_word (frame_word),
        .gap_expired(gap_expired),
        .gap_load   (gap_load),
        .gap_val    (gap_val),
        .done       (done),
        .rd_data    (rd_data),
        .mismatch   (mismatch)
    );

    prg_frame_engine #(
        .HI_CYC(HI_EFF),
        .LO_CYC(LO_EFF)
    ) u_engine (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (frame_go),
        .go_long(frame_long),
        .go_read(frame_read),
        .go_word(frame_word),
        .fin    (frame_fin),
        .rx_word(frame_rx),
        .ser_clk(pgm_clk),
        .ser_dat(pgm_dat_o),
        .ser_oe (pgm_dat_oe),
        .ser_in (pgm_dat_i)
    );

    prg_gap_timer #(
        .GW(GW)
    ) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (gap_load),
        .load_val(gap_val),
        .expired (gap_expired)
    );

endmodule

// File: rtl/prg_serial_host_chk.sv
// Protocol checker for prg_serial_host, attached with bind below.
// Assumes HI_MIN and LO_MIN are the effective half-periods of the bound instance.
module prg_serial_host_chk #(
    parameter int HI_MIN = 2,
    parameter int LO_MIN = 2
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic done,
    input logic pgm_clk,
    input logic pgm_dat_o,
    input logic pgm_dat_oe
);

    int hi_run;
    int lo_run;

    // Length of the current run of high and low serial clock cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= 0;
            lo_run <= LO_MIN;
        end else begin
            hi_run <= pgm_clk ? hi_run + 1 : 0;
            lo_run <= pgm_clk ? 0 : lo_run + 1;
        end
    end

    // R3: high half lasts at least the effective high period
    a_r3_high_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pgm_clk) |-> hi_run >= HI_MIN);

    // R3: low half lasts at least the effective low period
    a_r3_low_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pgm_clk) |-> lo_run >= LO_MIN);

    // R3: data and enable steady through the high half
    a_r3_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_clk && $past(pgm_clk)) |-> ($stable(pgm_dat_o) && $stable(pgm_dat_oe)));

    // R1: no new request accepted while a frame is clocking
    a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_clk |-> !req_ready);

    // R1: acceptance drops ready on the next cycle
    a_r1_accept_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R9: done lasts exactly one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind prg_serial_host prg_serial_host_chk #(
    .HI_MIN(HI_EFF),
    .LO_MIN(LO_EFF)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .pgm_clk   (pgm_clk),
    .pgm_dat_o (pgm_dat_o),
    .pgm_dat_oe(pgm_dat_oe)
);

// File: tb/tb_prg_serial_host.sv
`timescale 1ns/1ps
// Bench for prg_serial_host: a target model decodes the serial waveform,
// a vector table drives operations, directed checks cover reset and timing.
module tb_prg_serial_host;

    localparam int HALF_HI    = 3;
    localparam int HALF_LO    = 1;
    localparam int SETUP_HOLD = 2;
    localparam int T_DLY      = 10;
    localparam int T_PROG     = 40;
    localparam int T_DIS      = 25;
    localparam int HI_EXP     = 3;
    localparam int LO_EXP     = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [5:0]  req_cmd = 6'd0;
    logic [11:0] req_wdata = 12'd0;
    logic        done;
    logic [11:0] rd_data;
    logic        mismatch;
    logic        pgm_clk;
    logic        pgm_dat_o;
    logic        pgm_dat_oe;
    logic        dev_dat = 1'b1;

    always #2 clk = ~clk;

    prg_serial_host #(
        .HALF_HI(HALF_HI), .HALF_LO(HALF_LO), .SETUP_HOLD(SETUP_HOLD),
        .T_DLY(T_DLY), .T_PROG(T_PROG), .T_DIS(T_DIS)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_cmd(req_cmd), .req_wdata(req_wdata), .done(done),
        .rd_data(rd_data), .mismatch(mismatch), .pgm_clk(pgm_clk),
        .pgm_dat_o(pgm_dat_o), .pgm_dat_oe(pgm_dat_oe), .pgm_dat_i(dev_dat)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- target model ----------------
    int          cyc = 0;
    logic        pc_q = 1'b0, d_q = 1'b0, oe_q = 1'b1;
    int          mode = 0;             // 0 command, 1 write data, 2 read data
    int          nb = 0;
    logic [15:0] sh = '0;
    logic [13:0] out_w = '0;
    logic [11:0] mem [0:15];
    int          addr = 0;
    logic [11:0] latch_w = '0;
    logic        corrupt = 1'b0;
    int          last_fall = -100000, last_rise = -100000, last_chg = -100000;
    int          frame_end = -100000, need_gap = 0, need_kind = 0;
    int          min_hi = 1000, min_lo = 1000, min_setup = 1000, min_hold = 1000;
    int          gap_err = 0, long_err = 0, oe_err = 0, frm_err = 0;
    logic [5:0]  cmd_log [0:255];
    int          n_cmds = 0;

    initial for (int i = 0; i < 16; i++) mem[i] = 12'h000;

    task automatic decode(input logic [5:0] c);
        cmd_log[n_cmds % 256] = c;
        n_cmds++;
        need_gap = T_DLY; need_kind = 0;
        case (c)
            6'h02: mode = 1;
            6'h04: begin mode = 2; out_w = {2'b11, mem[addr]}; end
            6'h06: addr = (addr + 1) % 16;
            6'h08: begin mem[addr] = latch_w ^ (corrupt ? 12'h001 : 12'h000);
                         need_gap = T_PROG; need_kind = 1; end
            6'h0E: begin need_gap = T_DIS; need_kind = 1; end
            default: ;
        endcase
    endtask

    // Decode the serial port and measure every edge and gap
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (pgm_dat_o !== d_q || pgm_dat_oe !== oe_q) begin
                if (cyc - last_fall < min_hold) min_hold = cyc - last_fall;
                last_chg = cyc;
            end
            if (pgm_clk && !pc_q) begin
                if (nb == 0 && cyc - frame_end < need_gap) begin
                    if (need_kind == 1) long_err++; else gap_err++;
                end
                if (cyc - last_fall < min_lo) min_lo = cyc - last_fall;
                last_rise = cyc;
                if (mode == 2 && nb >= 1 && nb <= 14) dev_dat = out_w[nb-1];
                else dev_dat = 1'b1;
            end
            if (!pgm_clk && pc_q) begin
                if (cyc - last_rise < min_hi) min_hi = cyc - last_rise;
                if (mode != 2 && cyc - last_chg < min_setup) min_setup = cyc - last_chg;
                sh[nb] = pgm_dat_o;
                nb++;
                if (mode == 0 && nb == 6) begin
                    nb = 0; frame_end = cyc; decode(sh[5:0]);
                end else if (mode == 1 && nb == 16) begin
                    latch_w = sh[12:1];
                    if (sh[0] !== 1'b0 || sh[15:13] !== 3'b000) frm_err++;
                    nb = 0; mode = 0; frame_end = cyc; need_gap = T_DLY; need_kind = 0;
                end else if (mode == 2 && nb == 16) begin
                    nb = 0; mode = 0; frame_end = cyc; need_gap = T_DLY; need_kind = 0;
                end
                last_fall = cyc;
            end
            if (mode == 2 && (nb > 0 || pgm_clk) && pgm_dat_oe) oe_err++;
            if (mode != 2 && pgm_clk && !pgm_dat_oe) oe_err++;
        end
        pc_q = pgm_clk; d_q = pgm_dat_o; oe_q = pgm_dat_oe;
    end

    // ---------------- stimulus table ----------------
    typedef struct packed {
        logic [1:0]  op;
        logic [5:0]  cmd;
        logic [11:0] wd;
        logic [11:0] exp_rd;
        logic        exp_mis;
        logic        corrupt;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [0:NV-1] = '{
        '{2'd0, 6'h06, 12'h000, 12'h000, 1'b0, 1'b0},  // step to word 1
        '{2'd3, 6'h00, 12'hA5C, 12'hA5C, 1'b0, 1'b0},  // clean verify
        '{2'd2, 6'h00, 12'h000, 12'hA5C, 1'b0, 1'b0},  // read back
        '{2'd0, 6'h06, 12'h000, 12'h000, 1'b0, 1'b0},  // step to word 2
        '{2'd3, 6'h00, 12'h3F0, 12'h3F1, 1'b1, 1'b1},  // corrupted verify
        '{2'd1, 6'h00, 12'h123, 12'h000, 1'b0, 1'b0},  // load only
        '{2'd0, 6'h08, 12'h000, 12'h000, 1'b0, 1'b0},  // bare begin
        '{2'd0, 6'h0E, 12'h000, 12'h000, 1'b0, 1'b0},  // bare end
        '{2'd2, 6'h00, 12'h000, 12'h123, 1'b0, 1'b0},  // read loaded word
        '{2'd0, 6'h06, 12'h000, 12'h000, 1'b0, 1'b0},  // step to word 3
        '{2'd3, 6'h00, 12'hFFF, 12'hFFF, 1'b0, 1'b0},  // all ones
        '{2'd0, 6'h06, 12'h000, 12'h000, 1'b0, 1'b0},  // step to word 4
        '{2'd3, 6'h00, 12'h000, 12'h000, 1'b0, 1'b0}   // all zeros
    };

    // Issue one request and wait for its done pulse
    task automatic run_op(input vec_t v);
        int n0;
        int t;
        t = 0;
        while (!req_ready && t < 5000) begin @(negedge clk); t++; end
        corrupt   = v.corrupt;
        n0        = n_cmds;
        req_op    = v.op;
        req_cmd   = v.cmd;
        req_wdata = v.wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R1 ready after accept", int'(req_ready), 0);
        t = 0;
        while (!done && t < 5000) begin @(negedge clk); t++; end
        check(done == 1'b1, "R9 done seen", int'(done), 1);
        if (v.op == 2'd2 || v.op == 2'd3)
            check(rd_data == v.exp_rd, "R4 read word", int'(rd_data), int'(v.exp_rd));
        else
            check(rd_data == 12'h000, "R9 rd_data zero", int'(rd_data), 0);
        check(mismatch == v.exp_mis, "R8 mismatch flag", int'(mismatch), int'(v.exp_mis));
        if (v.op == 2'd3) begin
            check(n_cmds - n0 == 4, "R7 command count", n_cmds - n0, 4);
            check(cmd_log[n0 % 256] == 6'h02 && cmd_log[(n0+1) % 256] == 6'h08 &&
                  cmd_log[(n0+2) % 256] == 6'h0E && cmd_log[(n0+3) % 256] == 6'h04,
                  "R7 command order", int'(cmd_log[(n0+1) % 256]), 8);
        end
        @(negedge clk);
        check(done == 1'b0, "R9 done single cycle", int'(done), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: idle state right after reset
        check(req_ready == 1'b1, "R10 ready", int'(req_ready), 1);
        check(pgm_clk == 1'b0, "R10 clock low", int'(pgm_clk), 0);
        check(pgm_dat_oe == 1'b1 && pgm_dat_o == 1'b0, "R10 data idle",
              int'({pgm_dat_oe, pgm_dat_o}), 2);
        check(done == 1'b0, "R10 done low", int'(done), 0);

        for (int i = 0; i < NV; i++) run_op(VECS[i]);

        repeat (T_DLY + 10) @(negedge clk);
        // R2: bit order and frame framing seen by the model
        check(mem[1] == 12'hA5C, "R2 word 1 stored", int'(mem[1]), 'hA5C);
        check(mem[2] == 12'h123, "R2 word 2 stored", int'(mem[2]), 'h123);
        check(frm_err == 0, "R2 start/stop positions", frm_err, 0);
        // R3: half-periods and setup/hold
        check(min_hi == HI_EXP, "R3 high half", min_hi, HI_EXP);
        check(min_lo >= LO_EXP, "R3 low half clamp", min_lo, LO_EXP);
        check(min_setup >= SETUP_HOLD, "R3 setup", min_setup, SETUP_HOLD);
        check(min_hold >= SETUP_HOLD, "R3 hold", min_hold, SETUP_HOLD);
        // R4: data line released through read frames only
        check(oe_err == 0, "R4 line release", oe_err, 0);
        // R5 / R6: inter-frame gaps
        check(gap_err == 0, "R5 short gaps", gap_err, 0);
        check(long_err == 0, "R6 long gaps", long_err, 0);
        check(req_ready == 1'b1, "R1 ready when idle", int'(req_ready), 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    // Watchdog: ends a hung run as a failure
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule